// File: doc/BRIEF.md
# Single-Sample Conversion Sequencer Controller

This block is the register-mapped control logic for one converter sequence that takes a single sample. Software configures it over a simple word-addressed bus. The settings are an enable bit, a trigger-source field, an input channel, four per-sample control bits, a conversion-rate code and an interrupt mask. Software then writes a start bit. The block sends the channel number and a one-cycle start pulse to an external converter. It waits for that converter's done strobe and captures the 12-bit result. It then raises a completion flag, which software acknowledges by writing a one to a clear register.

Conversion starts are paced. The rate code and the `CLK_HZ` parameter give a minimum number of clock cycles between two start pulses. A request that arrives too early waits until the interval has passed. A request made while a conversion is running is held, and it is issued after the done strobe. Any further requests made meanwhile merge into that one held request. Channel numbers above 11 still go to the converter, but a status bit records that the channel was out of range.

Four states drive the controller. ST_IDLE waits for a held request. ST_PACE waits for the spacing interval to expire. ST_ISSUE drives the start pulse for one cycle. ST_BUSY waits for the done strobe. The transitions are:
- ST_IDLE to ST_ISSUE when a request is held, the sequence is enabled and the spacing has elapsed.
- ST_IDLE to ST_PACE when a request is held but the spacing has not elapsed.
- ST_PACE to ST_ISSUE when the spacing expires.
- ST_PACE back to ST_IDLE if the sequence is disabled.
- ST_ISSUE to ST_BUSY always.
- ST_BUSY to ST_IDLE on the done strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every readable register reads 0, and `irq` and `conv_start` are 0.
- R2: A start request is a write with bit 3 set to word address 0x5. It counts only when the enable bit is 1 (bit 3 of address 0x0) and the trigger field is 0 (bits 15:12 of address 0x1). If the block is idle and the spacing has elapsed, `conv_start` is high for exactly one cycle, two cycles after the write edge. During that pulse `conv_chan` equals bits 3:0 of address 0x2.
- R3: A start write while the trigger field is nonzero produces no start pulse.
- R4: A start write while the enable bit is 0 produces no start pulse. Clearing the enable bit also drops any held request.
- R5: A done strobe in ST_BUSY loads `conv_data` into bits 11:0 of the result register (address 0xA) one cycle later. The raw flag (bit 3 of address 0x6) sets one cycle after that, but only when the end-of-sequence control bit is 1. The control bits sit at address 0x3: bit 0 differential, bit 1 end-of-sequence, bit 2 interrupt-enable, bit 3 temperature.
- R6: Writing a 1 to bit 3 of address 0x9 clears the raw flag. If the flag is being set in the same cycle, the flag stays set.
- R7: `irq` and bit 3 of the masked status register (address 0x8) both equal the raw flag ANDed with bit 3 of the mask register (address 0x7).
- R8: The rate code is bits 3:0 of address 0x4. Codes 0x7, 0x5, 0x3 and 0x1 select 1M, 500K, 250K and 125K samples/s; any other code selects 125K. Consecutive start pulses are at least CLK_HZ/rate cycles apart. A request held back by this spacing issues exactly when the spacing expires.
- R9: A request made during a conversion is held and issued after the done strobe. Several such requests produce a single further start.
- R10: A channel value above 11 is still driven on `conv_chan`. Bit 8 of address 0x6 shows whether the channel of the last issued conversion was above 11.
- R11: Configuration registers read back only their defined fields, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from `bus_addr`) |
| irq | output | 1 | Completion interrupt |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 4 | Channel number for the converter |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter result |

## Verification
Two events can fall in the same clock edge: the completion flag being set by a finishing conversion, and software writing to the clear register. The bench waits until it sees the done strobe. It then times a clear write so that it lands exactly two edges later, on the edge where the flag sets. It expects the flag to read 1 afterwards. A second, isolated clear must then bring the flag back to 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PACE,
        ST_ISSUE,
        ST_BUSY
    } seq_state_t;

    localparam logic [3:0] A_ENABLE = 4'h0;
    localparam logic [3:0] A_TRIG   = 4'h1;
    localparam logic [3:0] A_CHAN   = 4'h2;
    localparam logic [3:0] A_SCTL   = 4'h3;
    localparam logic [3:0] A_RATE   = 4'h4;
    localparam logic [3:0] A_GO     = 4'h5;
    localparam logic [3:0] A_RAW    = 4'h6;
    localparam logic [3:0] A_MASK   = 4'h7;
    localparam logic [3:0] A_MSTAT  = 4'h8;
    localparam logic [3:0] A_CLR    = 4'h9;
    localparam logic [3:0] A_RESULT = 4'hA;

    function automatic int unsigned gap_cycles(input logic [3:0] code, input int unsigned clk_hz);
        int unsigned sps;
        int unsigned g;
        case (code)
            4'h7:    sps = 1000000;
            4'h5:    sps = 500000;
            4'h3:    sps = 250000;
            default: sps = 125000;
        endcase
        g = clk_hz / sps;
        if (g < 1) g = 1;
        return g;
    endfunction

endpackage

// File: rtl/adc_seq_pacer.sv
module adc_seq_pacer
    import adc_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ = 8_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rate_code,
    input  logic       issue,
    output logic       ready
);
    localparam int unsigned GAP_MAX = (CLK_HZ / 125000 < 1) ? 1 : CLK_HZ / 125000;
    localparam int unsigned CW      = $clog2(GAP_MAX + 1) + 1;

    logic [CW-1:0] gap;
    logic [CW-1:0] rem_q;

    assign gap   = CW'(gap_cycles(rate_code, CLK_HZ));
    assign ready = (rem_q <= CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)             rem_q <= '0;
        else if (issue)         rem_q <= gap - CW'(1);
        else if (rem_q != '0)   rem_q <= rem_q - CW'(1);
    end

    // checker: cycles since the previous start versus the spacing in force then
    logic [CW:0]   since_q;
    logic [CW-1:0] held_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '1;
            held_q  <= '0;
        end else if (issue) begin
            since_q <= (CW+1)'(1);
            held_q  <= gap;
        end else if (since_q != '1) begin
            since_q <= since_q + (CW+1)'(1);
        end
    end

    AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (since_q >= {1'b0, held_q})); // R8

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       pend,
    input  logic       ready,
    input  logic       conv_done,
    output logic       issue,
    output logic       busy
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en && pend) state_d = ready ? ST_ISSUE : ST_PACE;
            ST_PACE:  if (!en) state_d = ST_IDLE;
                      else if (ready) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_BUSY;
            ST_BUSY:  if (conv_done) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        issue = (state_q == ST_ISSUE);
        busy  = (state_q == ST_BUSY);
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue); // R2

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 8_000_000,
    parameter int unsigned DW       = 32,
    parameter int unsigned RW       = 12,
    parameter int unsigned CHW      = 4,
    parameter int unsigned CHAN_MAX = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [3:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          conv_start,
    output logic [CHW-1:0] conv_chan,
    input  logic          conv_done,
    input  logic [RW-1:0] conv_data
);
    localparam int unsigned SEQ_BIT = 3;

    logic           en_q, mask_q, raw_q, bad_q, pend_q, done_q;
    logic [3:0]     trig_q, sctl_q, rate_q;
    logic [CHW-1:0] chan_q, chan_hold_q;
    logic [RW-1:0]  result_q;
    logic           issue, busy, ready, req, done_ok, clr;

    assign req     = bus_wr && (bus_addr == A_GO) && bus_wdata[SEQ_BIT]
                     && en_q && (trig_q == 4'h0);
    assign clr     = bus_wr && (bus_addr == A_CLR) && bus_wdata[SEQ_BIT];
    assign done_ok = conv_done && busy;

    adc_seq_pacer #(.CLK_HZ(CLK_HZ)) u_pacer (
        .clk(clk), .rst_n(rst_n), .rate_code(rate_q), .issue(issue), .ready(ready)
    );

    adc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .pend(pend_q), .ready(ready),
        .conv_done(conv_done), .issue(issue), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trig_q <= '0;
            chan_q <= '0;
            sctl_q <= '0;
            rate_q <= '0;
            mask_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_ENABLE: en_q   <= bus_wdata[SEQ_BIT];
                A_TRIG:   trig_q <= bus_wdata[15:12];
                A_CHAN:   chan_q <= bus_wdata[CHW-1:0];
                A_SCTL:   sctl_q <= bus_wdata[3:0];
                A_RATE:   rate_q <= bus_wdata[3:0];
                A_MASK:   mask_q <= bus_wdata[SEQ_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            done_q      <= 1'b0;
            raw_q       <= 1'b0;
            bad_q       <= 1'b0;
            result_q    <= '0;
            chan_hold_q <= '0;
        end else begin
            if (!en_q)      pend_q <= 1'b0;
            else if (req)   pend_q <= 1'b1;
            else if (issue) pend_q <= 1'b0;
            if (issue) begin
                chan_hold_q <= chan_q;
                bad_q       <= (chan_q > CHW'(CHAN_MAX));
            end
            done_q <= done_ok;
            if (done_ok) result_q <= conv_data;
            if (done_q && sctl_q[1]) raw_q <= 1'b1;
            else if (clr)            raw_q <= 1'b0;
        end
    end

    assign conv_start = issue;
    assign conv_chan  = issue ? chan_q : chan_hold_q;
    assign irq        = raw_q & mask_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: bus_rdata[SEQ_BIT]   = en_q;
            A_TRIG:   bus_rdata[15:12]     = trig_q;
            A_CHAN:   bus_rdata[CHW-1:0]   = chan_q;
            A_SCTL:   bus_rdata[3:0]       = sctl_q;
            A_RATE:   bus_rdata[3:0]       = rate_q;
            A_RAW: begin
                bus_rdata[SEQ_BIT] = raw_q;
                bus_rdata[8]       = bad_q;
            end
            A_MASK:   bus_rdata[SEQ_BIT]   = mask_q;
            A_MSTAT:  bus_rdata[SEQ_BIT]   = raw_q & mask_q;
            A_RESULT: bus_rdata[RW-1:0]    = result_q;
            default: ;
        endcase
    end

    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_q) |-> !conv_start); // R4
    AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |=> (result_q == $past(conv_data))); // R5
    AST_RESULT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(done_ok, 2)); // R5
    AST_CHAN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(conv_chan)); // R10

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int unsigned CLK_HZ = 8_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, conv_start;
    logic [3:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nstarts = 0;
    int last_start = 0;
    int gap_seen = 0;
    int chan_seen = 0;
    int lat = 3;
    int cnt = 0;
    logic [11:0] model_val = '0;
    int done_cyc = 0;
    int irq_lag = -1;
    logic irq_prev = 1'b0;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        conv_done <= 1'b0;
        if (conv_start) begin
            cnt        <= lat;
            nstarts    <= nstarts + 1;
            gap_seen   <= cyc - last_start;
            last_start <= cyc;
            chan_seen  <= int'(conv_chan);
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= model_val;
            end
        end
    end

    always @(negedge clk) begin
        if (conv_done) done_cyc = cyc;
        if (irq && !irq_prev) irq_lag = cyc - done_cyc;
        irq_prev = irq;
    end

    initial begin
        while (cyc < 150000) @(posedge clk);
        $display("FAIL watchdog: actual cyc=%0d expected finish earlier", cyc);
        errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_flag(output int ok);
        int v;
        ok = 0;
        for (int i = 0; i < 600; i++) begin
            rd(4'h6, v);
            if (v[3]) begin ok = 1; break; end
        end
    endtask

    initial begin
        int v, ok, n0, exp_gap;
        logic [11:0] exp_val;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check("R1 reset read", v, 0);
        end
        check("R1 irq", int'(irq), 0);
        check("R1 conv_start", int'(conv_start), 0);

        // configure: single-ended, end-of-sequence, interrupt-enable (0x6), slowest rate
        wr(4'h3, 32'h6);
        wr(4'h4, 32'h1);
        wr(4'h7, 32'h8);
        wr(4'h0, 32'h8);

        // R2 start latency and channel
        wr(4'h2, 32'h1);
        model_val = 12'h000;
        wr(4'h5, 32'h8);
        check("R2 no start one cycle after write", int'(conv_start), 0);
        @(negedge clk);
        check("R2 start pulse", int'(conv_start), 1);
        check("R2 channel on pulse", int'(conv_chan), 1);
        @(negedge clk);
        check("R2 pulse ends", int'(conv_start), 0);
        wait_flag(ok);
        check("R5 flag after first", ok, 1);
        check("R5 result before flag (irq lag)", irq_lag, 2);
        wr(4'h9, 32'h8);

        // sweep all 16 channel codes
        for (int ch = 0; ch < 16; ch++) begin
            exp_val = (ch == 0) ? 12'h000 : (ch == 15) ? 12'hFFF : 12'(ch * 257);
            model_val = exp_val;
            wr(4'h2, 32'(ch));
            wr(4'h5, 32'h8);
            wait_flag(ok);
            check("R5 flag set", ok, 1);
            check("R2 channel seen", chan_seen, ch);
            rd(4'hA, v);
            check("R5 result", v, int'(exp_val));
            rd(4'h6, v);
            check("R10 range bit", (v >> 8) & 1, (ch > 11) ? 1 : 0);
            check("R7 irq with mask", int'(irq), 1);
            rd(4'h8, v);
            check("R7 masked status", v, 8);
            wr(4'h9, 32'h8);
            rd(4'h6, v);
            check("R6 clear", v & 8, 0);
            check("R7 irq after clear", int'(irq), 0);
        end
        wr(4'h2, 32'h2);

        // R7 mask off
        wr(4'h7, 32'h0);
        wr(4'h5, 32'h8);
        wait_flag(ok);
        check("R7 irq masked", int'(irq), 0);
        rd(4'h8, v);
        check("R7 masked status off", v, 0);
        wr(4'h9, 32'h8);
        wr(4'h7, 32'h8);

        // R3 nonzero trigger source ignores start
        wr(4'h1, 32'h0000_1000);
        idle(80);
        n0 = nstarts;
        wr(4'h5, 32'h8);
        idle(80);
        check("R3 no start with trigger set", nstarts, n0);
        wr(4'h1, 32'h0);

        // R4 disabled ignores start; pending dropped
        wr(4'h0, 32'h0);
        n0 = nstarts;
        wr(4'h5, 32'h8);
        idle(80);
        check("R4 no start when disabled", nstarts, n0);
        wr(4'h0, 32'h8);
        idle(80);
        check("R4 nothing pending after enable", nstarts, n0);

        // R5 end-of-sequence bit clear: result updates, no flag
        wr(4'h3, 32'h4);
        model_val = 12'h5A5;
        n0 = nstarts;
        wr(4'h5, 32'h8);
        idle(40);
        check("R5 converted", nstarts, n0 + 1);
        rd(4'hA, v);
        check("R5 result without flag", v, 'h5A5);
        rd(4'h6, v);
        check("R5 no flag when end bit 0", v & 8, 0);
        wr(4'h3, 32'h6);

        // R8 / R9 spacing per rate, back-to-back requests coalesce
        lat = 2;
        for (int k = 0; k < 5; k++) begin
            logic [3:0] code;
            code = (k == 0) ? 4'h7 : (k == 1) ? 4'h5 : (k == 2) ? 4'h3 : (k == 3) ? 4'h1 : 4'hA;
            exp_gap = (k == 0) ? 8 : (k == 1) ? 16 : (k == 2) ? 32 : 64;
            wr(4'h4, 32'(code));
            idle(80);
            n0 = nstarts;
            wr(4'h5, 32'h8);
            wr(4'h5, 32'h8);
            wr(4'h5, 32'h8);
            idle(150);
            check("R9 coalesced start count", nstarts, n0 + 2);
            check("R8 spacing", gap_seen, exp_gap);
            wr(4'h9, 32'h8);
        end

        // R9 request during a long conversion waits for done
        lat = 100;
        wr(4'h4, 32'h7);
        idle(20);
        n0 = nstarts;
        wr(4'h5, 32'h8);
        idle(3);
        wr(4'h5, 32'h8);
        idle(50);
        check("R9 held during busy", nstarts, n0 + 1);
        idle(150);
        check("R9 issued after done", nstarts, n0 + 2);
        check("R9 spacing beyond latency", (gap_seen > 100) ? 1 : 0, 1);
        idle(150);
        wr(4'h9, 32'h8);
        lat = 3;

        // R6 clear lands on the same edge as the flag set: flag stays
        wr(4'h5, 32'h8);
        do @(negedge clk); while (!conv_done);
        wr(4'h9, 32'h8);
        rd(4'h6, v);
        check("R6 set wins over clear", v & 8, 8);
        wr(4'h9, 32'h8);
        rd(4'h6, v);
        check("R6 plain clear", v & 8, 0);

        // R11 readback masking
        wr(4'h0, 32'h0);
        wr(4'h1, 32'hFFFF_FFFF);
        rd(4'h1, v);
        check("R11 trigger field", v, 'hF000);
        wr(4'h1, 32'h0);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'h2, v);
        check("R11 channel field", v, 'hF);
        wr(4'h3, 32'hFFFF_FFF9);
        rd(4'h3, v);
        check("R11 control field", v, 'h9);
        wr(4'h4, 32'hFFFF_FFF3);
        rd(4'h4, v);
        check("R11 rate field", v, 'h3);
        wr(4'h7, 32'hFFFF_FFFF);
        rd(4'h7, v);
        check("R11 mask field", v, 'h8);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v);
        check("R11 enable field", v, 'h8);
        rd(4'h5, v);
        check("R11 start reads zero", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule